// File: doc/BRIEF.md
# Lane-Mask-Aware Register Scoreboard

This block tracks register writes that are still in flight for each warp of a SIMT pipeline. A reservation is recorded as a register number with the lane mask of the instruction that will write it, plus a reference count. Issue logic asks whether a candidate instruction may go. The candidate collides only when one of its register operands matches a recorded register in its own warp and the two lane masks share at least one lane. As a result, divergent halves of a warp that write the same register under disjoint lanes do not block each other.

Identical reservations for the same warp, register and mask share one entry and raise its reference count. Writeback releases them by register and mask. A release that finds no matching entry does nothing except bump a miss counter, so writeback may send one release per SIMD set without removing duplicates. Each warp has a table of fixed depth. If a reservation cannot be stored, the block raises a stall for that cycle and sets a sticky overflow flag. Five event counters and a live-entry count let a bench confirm that nothing is left behind at the end of a run.

Top module: `lane_scoreboard`

## Requirements
- R1: After reset every table is empty, `pw_pending`, `stall`, `overflow`, `live_entries` and all five event counters are zero.
- R2: A reserve (`rsv_valid`) with a nonzero register and no equal (register, mask) entry in its warp stores a new entry with count 1 on the next clock edge, raises `live_entries` by one and `cnt_insert` by one. A reserve or release of register 0 has no effect and counts nothing.
- R3: A reserve whose (warp, register, mask) equals an existing entry allocates nothing: that entry's count goes up by one, `cnt_incr` goes up by one and `live_entries` is unchanged.
- R4: `q_collide` is combinational. It is 1 exactly when some nonzero register in `q_regs` (NQ slots, slot k in bits k*RW and up) equals the register of a valid entry of warp `q_warp` whose mask ANDed with `q_mask` is nonzero. Query slots holding 0 are ignored.
- R5: Reservations of the same register under disjoint masks in one warp are separate entries, each of which is hit only by overlapping query masks. Entries of one warp never cause a collision for another warp.
- R6: A release whose (warp, register, mask) matches an entry lowers its count by one and adds one to `cnt_rel_match`. When the count reaches zero the entry is removed, `cnt_erase` goes up by one and `live_entries` drops by one.
- R7: A release with a nonzero register that matches no entry changes no table and adds one to `cnt_rel_miss`.
- R8: `pw_pending` is 1 exactly when the table of warp `pw_warp` holds at least one entry.
- R9: A reserve that needs a new entry in a full table, or that would raise a count already at its maximum of 2^CNTW-1, drives `stall` high in the same cycle and is not stored. `overflow` becomes 1 on the next edge and stays 1 until reset.
- R10: A reserve and a release in the same cycle are both applied at the next edge, with the release applied first. The reserve therefore sees a slot or count that the release freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsv_valid | input | 1 | Reserve request |
| rsv_warp | input | WW | Warp of the reserve |
| rsv_reg | input | RW | Destination register to reserve |
| rsv_mask | input | LANES | Lane mask of the reserving instruction |
| rel_valid | input | 1 | Release request |
| rel_warp | input | WW | Warp of the release |
| rel_reg | input | RW | Register to release |
| rel_mask | input | LANES | Lane mask recorded with the reservation |
| q_warp | input | WW | Warp of the collision query |
| q_regs | input | NQ*RW | Operand registers of the candidate, 0 means unused |
| q_mask | input | LANES | Candidate lane mask |
| q_collide | output | 1 | Candidate collides with a pending write |
| pw_warp | input | WW | Warp of the pending-writes query |
| pw_pending | output | 1 | That warp has pending writes |
| stall | output | 1 | Current reserve cannot be stored |
| overflow | output | 1 | Sticky: a reserve was refused since reset |
| live_entries | output | LW | Number of valid entries over all warps |
| cnt_insert | output | EVW | New entries created |
| cnt_incr | output | EVW | Reference count increments |
| cnt_rel_match | output | EVW | Releases that matched an entry |
| cnt_rel_miss | output | EVW | Releases that matched nothing |
| cnt_erase | output | EVW | Entries removed |

## Verification
The bench builds the block with 2 warps, 8 registers, 4 lanes, 2 entries per warp, 2 query slots and a 2-bit reference count. This small configuration makes it cheap to sweep every query register against every one of the 16 lane masks. It also fills a table with only two reservations and reaches the count limit with three. The expected collision and counter values follow from the mask arithmetic and the order of operations. The same-cycle release-then-reserve path is exercised both for a shared entry and for a full table.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int unsigned SB_WARPS = 4;
    localparam int unsigned SB_REGS  = 16;
    localparam int unsigned SB_LANES = 8;
    localparam int unsigned SB_DEPTH = 4;
    localparam int unsigned SB_QRY   = 4;
    localparam int unsigned SB_CNTW  = 3;
    localparam int unsigned SB_EVW   = 16;

    // one-cycle table events reported by each warp table
    typedef struct packed {
        logic insert;
        logic incr;
        logic rmatch;
        logic rmiss;
        logic erase;
    } sb_ev_t;

    // index width that never collapses to zero
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sb_warp_table.sv
module sb_warp_table #(
    parameter int unsigned RW    = 4,
    parameter int unsigned LANES = 8,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CNTW  = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rel_en,
    input  logic [RW-1:0]            rel_reg,
    input  logic [LANES-1:0]         rel_mask,
    input  logic                     rsv_en,
    input  logic [RW-1:0]            rsv_reg,
    input  logic [LANES-1:0]         rsv_mask,
    output logic [DEPTH-1:0]         ent_v,
    output logic [DEPTH*RW-1:0]      ent_r,
    output logic [DEPTH*LANES-1:0]   ent_m,
    output sb_pkg::sb_ev_t           ev,
    output logic                     stall
);
    localparam int unsigned IW = sb_pkg::idx_w(DEPTH);

    typedef struct packed {
        logic             v;
        logic [RW-1:0]    r;
        logic [LANES-1:0] m;
        logic [CNTW-1:0]  c;
    } ent_t;

    ent_t tab [DEPTH];
    ent_t mid [DEPTH];
    ent_t nxt [DEPTH];

    logic          rel_hit, rsv_hit, rsv_free;
    logic [IW-1:0] hidx, fidx;

    always_comb begin
        // release stage works on the current table
        mid     = tab;
        ev      = '0;
        rel_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rel_en && tab[i].v && tab[i].r == rel_reg && tab[i].m == rel_mask) begin
                rel_hit = 1'b1;
                if (tab[i].c == CNTW'(1)) begin
                    mid[i]   = '0;
                    ev.erase = 1'b1;
                end else begin
                    mid[i].c = tab[i].c - CNTW'(1);
                end
            end
        end
        ev.rmatch = rel_hit;
        ev.rmiss  = rel_en && !rel_hit;

        // reserve stage works on the post-release table
        nxt      = mid;
        stall    = 1'b0;
        rsv_hit  = 1'b0;
        rsv_free = 1'b0;
        hidx     = '0;
        fidx     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (mid[i].v && mid[i].r == rsv_reg && mid[i].m == rsv_mask) begin
                rsv_hit = 1'b1;
                hidx    = IW'(i);
            end
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!mid[i].v) begin
                rsv_free = 1'b1;
                fidx     = IW'(i);
            end
        end
        if (rsv_en) begin
            if (rsv_hit) begin
                if (mid[hidx].c == '1) begin
                    stall = 1'b1;
                end else begin
                    nxt[hidx].c = mid[hidx].c + CNTW'(1);
                    ev.incr     = 1'b1;
                end
            end else if (rsv_free) begin
                nxt[fidx].v = 1'b1;
                nxt[fidx].r = rsv_reg;
                nxt[fidx].m = rsv_mask;
                nxt[fidx].c = CNTW'(1);
                ev.insert   = 1'b1;
            end else begin
                stall = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) tab[i] <= '0;
            else     tab[i] <= nxt[i];
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ent_v[i]                  = tab[i].v;
            ent_r[i*RW +: RW]         = tab[i].r;
            ent_m[i*LANES +: LANES]   = tab[i].m;
        end
    end

    // R3: coalescing keeps every (register, mask) pair unique
    for (genvar i = 0; i < DEPTH; i++) begin : g_uniq_i
        for (genvar j = i + 1; j < DEPTH; j++) begin : g_uniq_j
            a_r3_unique_pair: assert property (@(posedge clk) disable iff (rst)
                !(ent_v[i] && ent_v[j] &&
                  ent_r[i*RW +: RW] == ent_r[j*RW +: RW] &&
                  ent_m[i*LANES +: LANES] == ent_m[j*LANES +: LANES]));
        end
    end

    // R9: a refused reserve without a release leaves the table untouched
    a_r9_refused_no_write: assert property (@(posedge clk) disable iff (rst)
        (stall && !rel_en) |=> ($stable(ent_v) && $stable(ent_r) && $stable(ent_m)));

    // R6: occupancy follows inserts and erasures
    a_r6_occupancy: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(ent_v) ==
            $past($countones(ent_v)) + int'($past(ev.insert)) - int'($past(ev.erase))));

endmodule

// File: rtl/sb_collide.sv
module sb_collide #(
    parameter int unsigned RW    = 4,
    parameter int unsigned LANES = 8,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned NQ    = 4
) (
    input  logic [DEPTH-1:0]        ent_v,
    input  logic [DEPTH*RW-1:0]     ent_r,
    input  logic [DEPTH*LANES-1:0]  ent_m,
    input  logic [NQ*RW-1:0]        q_regs,
    input  logic [LANES-1:0]        q_mask,
    output logic                    hit
);
    logic [DEPTH-1:0] lane_ov;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ov
        assign lane_ov[i] = ent_v[i] && |(ent_m[i*LANES +: LANES] & q_mask);
    end

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NQ; k++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (q_regs[k*RW +: RW] != '0 && lane_ov[i] &&
                    ent_r[i*RW +: RW] == q_regs[k*RW +: RW])
                    hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lane_scoreboard.sv
module lane_scoreboard #(
    parameter int unsigned NWARP = sb_pkg::SB_WARPS,
    parameter int unsigned NREG  = sb_pkg::SB_REGS,
    parameter int unsigned LANES = sb_pkg::SB_LANES,
    parameter int unsigned DEPTH = sb_pkg::SB_DEPTH,
    parameter int unsigned NQ    = sb_pkg::SB_QRY,
    parameter int unsigned CNTW  = sb_pkg::SB_CNTW,
    parameter int unsigned EVW   = sb_pkg::SB_EVW,
    localparam int unsigned WW   = sb_pkg::idx_w(NWARP),
    localparam int unsigned RW   = sb_pkg::idx_w(NREG),
    localparam int unsigned LW   = $clog2(NWARP * DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rsv_valid,
    input  logic [WW-1:0]      rsv_warp,
    input  logic [RW-1:0]      rsv_reg,
    input  logic [LANES-1:0]   rsv_mask,
    input  logic               rel_valid,
    input  logic [WW-1:0]      rel_warp,
    input  logic [RW-1:0]      rel_reg,
    input  logic [LANES-1:0]   rel_mask,
    input  logic [WW-1:0]      q_warp,
    input  logic [NQ*RW-1:0]   q_regs,
    input  logic [LANES-1:0]   q_mask,
    output logic               q_collide,
    input  logic [WW-1:0]      pw_warp,
    output logic               pw_pending,
    output logic               stall,
    output logic               overflow,
    output logic [LW-1:0]      live_entries,
    output logic [EVW-1:0]     cnt_insert,
    output logic [EVW-1:0]     cnt_incr,
    output logic [EVW-1:0]     cnt_rel_match,
    output logic [EVW-1:0]     cnt_rel_miss,
    output logic [EVW-1:0]     cnt_erase
);
    logic [DEPTH-1:0]        tv [NWARP];
    logic [DEPTH*RW-1:0]     tr [NWARP];
    logic [DEPTH*LANES-1:0]  tm [NWARP];
    sb_pkg::sb_ev_t          tev [NWARP];
    logic [NWARP-1:0]        w_stall;
    logic [NWARP-1:0]        ins_v, inc_v, rm_v, rx_v, er_v;

    for (genvar g = 0; g < NWARP; g++) begin : g_warp
        logic rel_en_w, rsv_en_w;
        assign rel_en_w = rel_valid && rel_warp == WW'(g) && rel_reg != '0;
        assign rsv_en_w = rsv_valid && rsv_warp == WW'(g) && rsv_reg != '0;

        sb_warp_table #(.RW(RW), .LANES(LANES), .DEPTH(DEPTH), .CNTW(CNTW)) u_tab (
            .clk      (clk),
            .rst      (rst),
            .rel_en   (rel_en_w),
            .rel_reg  (rel_reg),
            .rel_mask (rel_mask),
            .rsv_en   (rsv_en_w),
            .rsv_reg  (rsv_reg),
            .rsv_mask (rsv_mask),
            .ent_v    (tv[g]),
            .ent_r    (tr[g]),
            .ent_m    (tm[g]),
            .ev       (tev[g]),
            .stall    (w_stall[g])
        );

        assign ins_v[g] = tev[g].insert;
        assign inc_v[g] = tev[g].incr;
        assign rm_v[g]  = tev[g].rmatch;
        assign rx_v[g]  = tev[g].rmiss;
        assign er_v[g]  = tev[g].erase;
    end

    sb_collide #(.RW(RW), .LANES(LANES), .DEPTH(DEPTH), .NQ(NQ)) u_coll (
        .ent_v  (tv[q_warp]),
        .ent_r  (tr[q_warp]),
        .ent_m  (tm[q_warp]),
        .q_regs (q_regs),
        .q_mask (q_mask),
        .hit    (q_collide)
    );

    assign pw_pending = |tv[pw_warp];
    assign stall      = |w_stall;

    always_comb begin
        int n;
        n = 0;
        for (int w = 0; w < NWARP; w++) n += $countones(tv[w]);
        live_entries = LW'(n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow      <= 1'b0;
            cnt_insert    <= '0;
            cnt_incr      <= '0;
            cnt_rel_match <= '0;
            cnt_rel_miss  <= '0;
            cnt_erase     <= '0;
        end else begin
            overflow      <= overflow | stall;
            cnt_insert    <= cnt_insert    + EVW'($countones(ins_v));
            cnt_incr      <= cnt_incr      + EVW'($countones(inc_v));
            cnt_rel_match <= cnt_rel_match + EVW'($countones(rm_v));
            cnt_rel_miss  <= cnt_rel_miss  + EVW'($countones(rx_v));
            cnt_erase     <= cnt_erase     + EVW'($countones(er_v));
        end
    end

    // R9: overflow is sticky and follows every refusal
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    a_r9_stall_sets_flag: assert property (@(posedge clk) disable iff (rst)
        stall |=> overflow);

    // R4: a query with no lanes never collides
    a_r4_no_lanes_no_hit: assert property (@(posedge clk) disable iff (rst)
        (q_mask == '0) |-> !q_collide);

    // R8: with every table empty no warp reports pending writes
    a_r8_empty_not_pending: assert property (@(posedge clk) disable iff (rst)
        (live_entries == '0) |-> !pw_pending);

endmodule

// File: tb/lane_scoreboard_test.sv
`timescale 1ns/1ps
module lane_scoreboard_test;
    localparam int NWARP = 2, NREG = 8, LANES = 4, DEPTH = 2, NQ = 2, CNTW = 2, EVW = 8;
    localparam int WW = 1, RW = 3, LW = 3;

    logic clk = 0, rst = 1;
    logic rsv_valid = 0, rel_valid = 0;
    logic [WW-1:0] rsv_warp = 0, rel_warp = 0, q_warp = 0, pw_warp = 0;
    logic [RW-1:0] rsv_reg = 0, rel_reg = 0;
    logic [LANES-1:0] rsv_mask = 0, rel_mask = 0, q_mask = 0;
    logic [NQ*RW-1:0] q_regs = 0;
    logic q_collide, pw_pending, stall, overflow;
    logic [LW-1:0] live_entries;
    logic [EVW-1:0] cnt_insert, cnt_incr, cnt_rel_match, cnt_rel_miss, cnt_erase;

    int nchk = 0, nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lane_scoreboard #(.NWARP(NWARP), .NREG(NREG), .LANES(LANES), .DEPTH(DEPTH),
                      .NQ(NQ), .CNTW(CNTW), .EVW(EVW)) uut (
        .clk(clk), .rst(rst),
        .rsv_valid(rsv_valid), .rsv_warp(rsv_warp), .rsv_reg(rsv_reg), .rsv_mask(rsv_mask),
        .rel_valid(rel_valid), .rel_warp(rel_warp), .rel_reg(rel_reg), .rel_mask(rel_mask),
        .q_warp(q_warp), .q_regs(q_regs), .q_mask(q_mask), .q_collide(q_collide),
        .pw_warp(pw_warp), .pw_pending(pw_pending), .stall(stall), .overflow(overflow),
        .live_entries(live_entries), .cnt_insert(cnt_insert), .cnt_incr(cnt_incr),
        .cnt_rel_match(cnt_rel_match), .cnt_rel_miss(cnt_rel_miss), .cnt_erase(cnt_erase)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_rsv(input int w, input int r, input int m);
        rsv_valid = 1; rsv_warp = WW'(w); rsv_reg = RW'(r); rsv_mask = LANES'(m);
    endtask

    task automatic set_rel(input int w, input int r, input int m);
        rel_valid = 1; rel_warp = WW'(w); rel_reg = RW'(r); rel_mask = LANES'(m);
    endtask

    task automatic apply();
        @(negedge clk);
        rsv_valid = 0; rel_valid = 0;
    endtask

    task automatic reserve(input int w, input int r, input int m);
        set_rsv(w, r, m); apply();
    endtask

    task automatic release_op(input int w, input int r, input int m);
        set_rel(w, r, m); apply();
    endtask

    function automatic int query(input int w, input int r0, input int r1, input int m);
        return 0;
    endfunction

    task automatic ask(input int w, input int r0, input int r1, input int m, output int hit);
        q_warp = WW'(w); q_regs = {RW'(r1), RW'(r0)}; q_mask = LANES'(m);
        #1 hit = int'(q_collide);
    endtask

    task automatic pend(input int w, output int p);
        pw_warp = WW'(w);
        #1 p = int'(pw_pending);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R1 watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int h, p;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 live", int'(live_entries), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 stall", int'(stall), 0);
        chk("R1 counters", int'(cnt_insert) + int'(cnt_incr) + int'(cnt_rel_match)
            + int'(cnt_rel_miss) + int'(cnt_erase), 0);
        pend(0, p); chk("R1 pending w0", p, 0);
        pend(1, p); chk("R1 pending w1", p, 0);

        // R2 register 0 is never tracked
        @(negedge clk);
        reserve(0, 0, 15);
        chk("R2 reg0 live", int'(live_entries), 0);
        chk("R2 reg0 insert", int'(cnt_insert), 0);

        // R2 first reservation
        reserve(0, 3, 4'b0011);
        chk("R2 live", int'(live_entries), 1);
        chk("R2 insert", int'(cnt_insert), 1);
        pend(0, p); chk("R8 pending w0", p, 1);
        pend(1, p); chk("R8 pending w1", p, 0);

        // R4/R5 sweep every register and mask over both query slots and both warps
        for (int r = 0; r < NREG; r++) begin
            for (int m = 0; m < 16; m++) begin
                int e;
                e = (r == 3 && (m & 3) != 0) ? 1 : 0;
                ask(0, 0, r, m, h); chk($sformatf("R4 slot1 r%0d m%0d", r, m), h, e);
                ask(0, r, 7, m, h); chk($sformatf("R4 slot0 r%0d m%0d", r, m), h, e);
                ask(1, r, 0, m, h); chk($sformatf("R5 other warp r%0d m%0d", r, m), h, 0);
            end
        end

        // R3 coalescing
        reserve(0, 3, 4'b0011);
        chk("R3 incr", int'(cnt_incr), 1);
        chk("R3 live", int'(live_entries), 1);

        // R5 disjoint mask gets its own entry
        reserve(0, 3, 4'b1100);
        chk("R5 live", int'(live_entries), 2);
        chk("R5 insert", int'(cnt_insert), 2);
        ask(0, 3, 0, 4'b0100, h); chk("R5 upper half hit", h, 1);
        ask(0, 3, 0, 4'b0001, h); chk("R5 lower half hit", h, 1);

        // R9 full table refuses a new entry
        set_rsv(0, 5, 4'b0001);
        #1 chk("R9 stall full", int'(stall), 1);
        apply();
        chk("R9 live unchanged", int'(live_entries), 2);
        chk("R9 overflow", int'(overflow), 1);
        chk("R9 insert unchanged", int'(cnt_insert), 2);
        ask(0, 5, 0, 4'b0001, h); chk("R9 not stored", h, 0);

        // R3 count to max, R9 refusal at max
        set_rsv(0, 3, 4'b0011);
        #1 chk("R3 no stall", int'(stall), 0);
        apply();
        chk("R3 incr 2", int'(cnt_incr), 2);
        set_rsv(0, 3, 4'b0011);
        #1 chk("R9 stall count max", int'(stall), 1);
        apply();
        chk("R9 incr unchanged", int'(cnt_incr), 2);
        chk("R9 overflow held", int'(overflow), 1);

        // R7 unmatched releases
        release_op(0, 3, 4'b0111);
        chk("R7 miss mask", int'(cnt_rel_miss), 1);
        chk("R7 live", int'(live_entries), 2);
        release_op(1, 3, 4'b0011);
        chk("R7 miss warp", int'(cnt_rel_miss), 2);
        ask(0, 3, 0, 4'b1000, h); chk("R7 entries kept", h, 1);
        release_op(0, 0, 4'b0011);
        chk("R2 reg0 release miss", int'(cnt_rel_miss), 2);
        chk("R2 reg0 release match", int'(cnt_rel_match), 0);

        // R6 erase of the single-count entry
        release_op(0, 3, 4'b1100);
        chk("R6 match", int'(cnt_rel_match), 1);
        chk("R6 erase", int'(cnt_erase), 1);
        chk("R6 live", int'(live_entries), 1);
        ask(0, 3, 0, 4'b0100, h); chk("R6 freed lanes", h, 0);
        ask(0, 3, 0, 4'b0001, h); chk("R6 other kept", h, 1);

        // R6 count 3 drains over three releases
        release_op(0, 3, 4'b0011);
        release_op(0, 3, 4'b0011);
        chk("R6 still live", int'(live_entries), 1);
        chk("R6 no early erase", int'(cnt_erase), 1);
        release_op(0, 3, 4'b0011);
        chk("R6 match 4", int'(cnt_rel_match), 4);
        chk("R6 erase 2", int'(cnt_erase), 2);
        chk("R6 live 0", int'(live_entries), 0);
        pend(0, p); chk("R8 drained w0", p, 0);

        // R10 same-cycle release then reserve of one pair
        reserve(1, 2, 4'b1111);
        chk("R10 setup insert", int'(cnt_insert), 3);
        set_rel(1, 2, 4'b1111); set_rsv(1, 2, 4'b1111);
        apply();
        chk("R10 live", int'(live_entries), 1);
        chk("R10 erase", int'(cnt_erase), 3);
        chk("R10 insert", int'(cnt_insert), 4);
        chk("R10 match", int'(cnt_rel_match), 5);
        chk("R10 incr", int'(cnt_incr), 2);

        // R10 release frees a slot in a full table for the reserve
        reserve(1, 4, 4'b0001);
        chk("R10 full", int'(live_entries), 2);
        set_rel(1, 2, 4'b1111); set_rsv(1, 6, 4'b0010);
        #1 chk("R10 no stall", int'(stall), 0);
        apply();
        chk("R10 live full", int'(live_entries), 2);
        chk("R10 insert 6", int'(cnt_insert), 6);
        chk("R10 erase 4", int'(cnt_erase), 4);
        ask(1, 6, 0, 4'b0010, h); chk("R10 new entry hit", h, 1);
        ask(1, 2, 0, 4'b1111, h); chk("R10 old entry gone", h, 0);
        pend(1, p); chk("R8 pending w1", p, 1);

        // final drain: nothing leaks
        release_op(1, 4, 4'b0001);
        release_op(1, 6, 4'b0010);
        chk("R6 final live", int'(live_entries), 0);
        chk("R6 final match", int'(cnt_rel_match), 8);
        chk("R6 inserts equal erasures", int'(cnt_insert), int'(cnt_erase));
        pend(1, p); chk("R8 drained w1", p, 0);
        chk("R9 overflow sticky", int'(overflow), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule